// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a 24-bit periodic down-counter that produces a tick interrupt request for an operating system scheduler. Software programs a reload value and turns the counter on through four word registers on a simple synchronous bus. Each counting step lowers the count by one. The step after the count reaches zero loads the reload value again, so one tick period is reload + 1 steps.

Every zero-reach sets a sticky completion flag. When interrupt generation is on, it also raises a one-cycle request. A control bit picks what counts as a step. It is either every processor clock or each rising edge of an external reference input. The reference input passes through a two-flop synchronizer and an edge detector before it is used.

Software reads the completion flag in the control/status register, and that read clears the flag. A write of any data to the current-value register zeroes both the count and the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status register (word offset 0x10) reads 0x00000000, or 0x00000004 when the build has no reference input (HAS_REF=0). Reload (0x14) and current value (0x18) read 0. Calibration (0x1C) reads the CAL_VALUE parameter.
- R2: In control/status, bit 0 enables counting, bit 1 enables the interrupt request and bit 2 selects the step source (1 = processor clock, 0 = external reference). Bit 16 is the completion flag. All other bits read 0, and writes to them have no effect.
- R3: Reload and current value hold 24 bits. Bits 31:24 of both always read 0.
- R4: With counting enabled on the processor clock, every clock is one step. A step at count 0 loads the reload value, and any other step subtracts one. Starting from count 0, the value after n steps is reload - ((n-1) mod (reload+1)).
- R5: With bit 0 clear, the count does not change.
- R6: With the external source selected, each rising edge of ref_in gives exactly one step once it has passed the two-flop synchronizer. A constant ref_in gives no steps.
- R7: A step that takes the count from 1 to 0 sets the flag. The flag stays set until control/status is read. That read returns 1 in bit 16, and the next read returns 0.
- R8: When a control/status read and a zero-reach step fall in the same cycle, the read returns the old flag and the flag ends up set.
- R9: A write of any data to the current-value register sets the count to 0 and clears the flag.
- R10: tick_irq is high for exactly one cycle after each zero-reach step when bit 1 is set. It is high in the same cycle that the count first reads 0. When bit 1 is clear, tick_irq stays low but the flag is still set.
- R11: With reload 0, once the count is 0 it stays 0 and produces no further zero-reach events.
- R12: The calibration register is read-only. Writes to it leave its read value at CAL_VALUE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous external reference level |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe. Read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| tick_irq | output | 1 | One-cycle interrupt request per zero-reach |

## Verification
The bench sweeps reload values 0 to 5 with the interrupt enable both on and off, and compares the count and tick_irq every cycle against the closed-form sequence. A design with an off-by-one period, or one that fires on the reload step instead of the zero-reach, fails at once. It places a control/status read in exactly the cycle of a zero-reach step; a design that lets the read-clear win would lose that tick. It also feeds slow pulses on ref_in and checks the step count, which catches a level-sensitive design that counts every clock while the input is high. It also writes to the current-value register after events and checks that the flag is cleared, and it checks the reset value of a build without a reference input.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types for the tick timer.
// Assumes word-aligned byte addresses; word indices are fixed because
// software drivers decode them.
package tick_timer_pkg;

    localparam int WIDX_CTRL   = 4;   // byte offset 0x10
    localparam int WIDX_RELOAD = 5;   // byte offset 0x14
    localparam int WIDX_CUR    = 6;   // byte offset 0x18
    localparam int WIDX_CALIB  = 7;   // byte offset 0x1C

    localparam int BIT_EN   = 0;
    localparam int BIT_INT  = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CUR,
        SEL_CALIB
    } reg_sel_e;

    // Map a word index onto a register selector.
    function automatic reg_sel_e decode_word(input int widx);
        case (widx)
            WIDX_CTRL:   return SEL_CTRL;
            WIDX_RELOAD: return SEL_RELOAD;
            WIDX_CUR:    return SEL_CUR;
            WIDX_CALIB:  return SEL_CALIB;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tick_timer_refsync.sv
// Brings the asynchronous reference level into the clk domain through
// SYNC_STAGES flops and emits a one-cycle pulse per rising edge.
// Assumes the reference is much slower than clk (at least two clk per level).
module tick_timer_refsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // First synchronizer stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ref_in;
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            // Further synchronizer stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign ref_tick = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/tick_timer_core.sv
// Counting engine: down-counter with reload, sticky completion flag and
// interrupt pulse. A current-value write overrides a step in the same
// cycle; a zero-reach beats a read-clear of the flag.
module tick_timer_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             ctrl_int,
    input  logic             ctrl_src,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             cur_wr,
    input  logic             flag_rd_clr,
    output logic [CNT_W-1:0] cur_q,
    output logic             flag_q,
    output logic             tick_irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic step;
    logic zero_hit;

    assign step     = ctrl_en & (ctrl_src | ref_tick);
    assign zero_hit = step & ~cur_wr & (cur_q == CNT_ONE);

    // Count register: clear on write, reload at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_q <= '0;
        else if (cur_wr)     cur_q <= '0;
        else if (step) begin
            if (cur_q == '0) cur_q <= reload_q;
            else             cur_q <= cur_q - CNT_ONE;
        end
    end

    // Sticky completion flag with set priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (zero_hit)               flag_q <= 1'b1;
        else if (cur_wr || flag_rd_clr)  flag_q <= 1'b0;
    end

    // One-cycle interrupt request per zero-reach when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_irq <= 1'b0;
        else        tick_irq <= zero_hit & ctrl_int;
    end

endmodule

// File: rtl/tick_timer_regs.sv
// Register decode: control bits, reload storage, current-value write
// strobe, flag read-clear strobe and the read-data multiplexer.
// Read data is combinational and zero when no read is active.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 24,
    parameter bit          HAS_REF   = 1'b1,
    parameter logic [31:0] CAL_VALUE = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  cur_q,
    input  logic              flag_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctrl_en,
    output logic              ctrl_int,
    output logic              ctrl_src,
    output logic [CNT_W-1:0]  reload_q,
    output logic              cur_wr,
    output logic              flag_rd_clr
);

    reg_sel_e sel;
    logic     ctrl_wr;
    logic     unused_wdata;

    // Decode the word-aligned address into a register selector.
    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) sel = decode_word(int'(bus_addr[ADDR_W-1:2]));
    end

    assign ctrl_wr      = bus_wr & (sel == SEL_CTRL);
    assign cur_wr       = bus_wr & (sel == SEL_CUR);
    assign flag_rd_clr  = bus_rd & (sel == SEL_CTRL);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    // Enable and interrupt-enable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_int <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_en  <= bus_wdata[BIT_EN];
            ctrl_int <= bus_wdata[BIT_INT];
        end
    end

    generate
        if (HAS_REF) begin : g_src_rw
            logic src_q;
            // Source select is writable when a reference input exists.
            always_ff @(posedge clk) begin
                if (!rst_n)       src_q <= 1'b0;
                else if (ctrl_wr) src_q <= bus_wdata[BIT_SRC];
            end
            assign ctrl_src = src_q;
        end else begin : g_src_fixed
            assign ctrl_src = 1'b1;
        end
    endgenerate

    // Reload value storage, low CNT_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              reload_q <= '0;
        else if (bus_wr && sel == SEL_RELOAD)    reload_q <= bus_wdata[CNT_W-1:0];
    end

    // Read-data multiplexer with reserved bits forced to zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CTRL: begin
                    bus_rdata[BIT_EN]   = ctrl_en;
                    bus_rdata[BIT_INT]  = ctrl_int;
                    bus_rdata[BIT_SRC]  = ctrl_src;
                    bus_rdata[BIT_FLAG] = flag_q;
                end
                SEL_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
                SEL_CUR:    bus_rdata[CNT_W-1:0] = cur_q;
                SEL_CALIB:  bus_rdata = DATA_W'(CAL_VALUE);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Top of the periodic tick timer: reference synchronizer, register
// decode and counting engine. Assumes CNT_W < DATA_W and ADDR_W >= 6.
module tick_timer #(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          CNT_W       = 24,
    parameter int          SYNC_STAGES = 2,
    parameter bit          HAS_REF     = 1'b1,
    parameter logic [31:0] CAL_VALUE   = 32'h4000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    logic             ref_tick;
    logic             ctrl_en;
    logic             ctrl_int;
    logic             ctrl_src;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_q;
    logic             cur_wr;
    logic             flag_rd_clr;
    logic             flag_q;

    tick_timer_refsync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_refsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .ref_tick (ref_tick)
    );

    tick_timer_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .HAS_REF   (HAS_REF),
        .CAL_VALUE (CAL_VALUE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .cur_q       (cur_q),
        .flag_q      (flag_q),
        .bus_rdata   (bus_rdata),
        .ctrl_en     (ctrl_en),
        .ctrl_int    (ctrl_int),
        .ctrl_src    (ctrl_src),
        .reload_q    (reload_q),
        .cur_wr      (cur_wr),
        .flag_rd_clr (flag_rd_clr)
    );

    tick_timer_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .ctrl_int    (ctrl_int),
        .ctrl_src    (ctrl_src),
        .ref_tick    (ref_tick),
        .reload_q    (reload_q),
        .cur_wr      (cur_wr),
        .flag_rd_clr (flag_rd_clr),
        .cur_q       (cur_q),
        .flag_q      (flag_q),
        .tick_irq    (tick_irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the tick timer, attached by bind below.
module tick_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic              ctrl_en,
    input logic              ctrl_int,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic              cur_wr,
    input logic              flag_q
);

    logic cnt_reg_rd;
    assign cnt_reg_rd = bus_rd && (bus_addr[1:0] == 2'b00) &&
                        ((bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5)) ||
                         (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(6)));

    AST_IRQ_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) tick_irq |=> !tick_irq); // R10
    AST_IRQ_AT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) tick_irq |-> (cur_q == '0)); // R10
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) tick_irq |-> $past(ctrl_int)); // R10
    AST_IRQ_FLAGGED:  assert property (@(posedge clk) disable iff (!rst_n) tick_irq |-> flag_q); // R7
    AST_CUR_WR_CLR:   assert property (@(posedge clk) disable iff (!rst_n) cur_wr |=> (cur_q == '0 && !flag_q)); // R9
    AST_HOLD_OFF:     assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_en && !cur_wr) |=> $stable(cur_q)); // R5
    AST_RELOAD_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (reload_q == '0 && cur_q == '0 && !cur_wr) |=> (cur_q == '0)); // R11
    AST_RSV_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) cnt_reg_rd |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R3

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq),
    .ctrl_en   (ctrl_en),
    .ctrl_int  (ctrl_int),
    .reload_q  (reload_q),
    .cur_q     (cur_q),
    .cur_wr    (cur_wr),
    .flag_q    (flag_q)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

    localparam logic [31:0] CAL   = 32'h4000_2710;
    localparam logic [7:0]  A_CTL = 8'h10;
    localparam logic [7:0]  A_RLD = 8'h14;
    localparam logic [7:0]  A_CUR = 8'h18;
    localparam logic [7:0]  A_CAL = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] noref_rdata;
    logic        tick_irq;
    logic        noref_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] rd_val;
    logic [31:0] rd_noref;

    always #10 clk = ~clk;

    tick_timer #(.CAL_VALUE(CAL)) i_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    tick_timer #(.CAL_VALUE(CAL), .HAS_REF(1'b0)) i_tick_timer_noref (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(noref_rdata), .tick_irq(noref_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        rd_val = bus_rdata;
        rd_noref = noref_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] exp_cur;
        logic [31:0] hold_a;
        bit          exp_irq;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_CTL);
        check(rd_val == 32'h0, "R1 ctrl reset", rd_val, 32'h0);
        check(rd_noref == 32'h4, "R1 ctrl reset no-ref", rd_noref, 32'h4);
        rd(A_RLD); check(rd_val == 32'h0, "R1 reload reset", rd_val, 32'h0);
        rd(A_CUR); check(rd_val == 32'h0, "R1 current reset", rd_val, 32'h0);
        rd(A_CAL); check(rd_val == CAL, "R1 calib reset", rd_val, CAL);

        // R12: calibration writes ignored
        wr(A_CAL, 32'h0000_1234);
        rd(A_CAL); check(rd_val == CAL, "R12 calib read-only", rd_val, CAL);

        // R3: 24-bit reload, upper bits read zero
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD); check(rd_val == 32'h00FF_FFFF, "R3 reload width", rd_val, 32'h00FF_FFFF);
        wr(A_CUR, 32'h0);

        // R2: only control bits 2:0 writable
        wr(A_CTL, 32'hFFFF_FFFF);
        rd(A_CTL); check(rd_val == 32'h7, "R2 ctrl bits", rd_val, 32'h7);
        rd(A_CUR); check(rd_val[31:24] == 8'h0, "R3 current upper zero", rd_val, rd_val & 32'h00FF_FFFF);

        // R5: disabled counter holds
        wr(A_CTL, 32'h6);
        rd(A_CTL); check(rd_val == 32'h6, "R2 ctrl readback", rd_val, 32'h6);
        rd(A_CUR); hold_a = rd_val;
        repeat (10) @(negedge clk);
        rd(A_CUR); check(rd_val == hold_a && hold_a != 0, "R5 hold when disabled", rd_val, hold_a);

        // R4/R10/R11/R7: sweep reload and interrupt enable
        for (int r = 0; r <= 5; r++) begin
            for (int ti = 0; ti <= 1; ti++) begin
                wr(A_CTL, 32'h0);
                wr(A_RLD, 32'(r));
                wr(A_CUR, 32'h0);
                wr(A_CTL, ti ? 32'h7 : 32'h5);
                bus_addr = A_CUR; bus_rd = 1'b1;
                #1;
                check(bus_rdata == 32'h0, "R4 start count", bus_rdata, 32'h0);
                for (int n = 1; n <= 14; n++) begin
                    @(negedge clk);
                    #1;
                    exp_cur = 32'(r - ((n - 1) % (r + 1)));
                    exp_irq = (ti == 1) && (r > 0) && ((n % (r + 1)) == 0);
                    check(bus_rdata == exp_cur, (r == 0) ? "R11 reload zero count" : "R4 count sequence",
                          bus_rdata, exp_cur);
                    check(tick_irq == exp_irq, ti ? "R10 irq pulse" : "R10 irq masked",
                          32'(tick_irq), 32'(exp_irq));
                end
                bus_rd = 1'b0;
                wr(A_CTL, 32'h0);
                rd(A_CTL);
                check(rd_val == ((r > 0) ? 32'h0001_0000 : 32'h0), "R7 flag after sweep",
                      rd_val, (r > 0) ? 32'h0001_0000 : 32'h0);
                rd(A_CTL);
                check(rd_val == 32'h0, "R7 flag cleared by read", rd_val, 32'h0);
            end
        end

        // R8: read of control coincides with zero-reach
        wr(A_CTL, 32'h0);
        wr(A_RLD, 32'd3);
        wr(A_CUR, 32'h0);
        wr(A_CTL, 32'h5);
        repeat (3) @(negedge clk);
        bus_addr = A_CTL; bus_rd = 1'b1;
        #1;
        check(bus_rdata == 32'h5, "R8 read before zero-reach", bus_rdata, 32'h5);
        @(negedge clk);
        bus_rd = 1'b0;
        wr(A_CTL, 32'h0);
        rd(A_CTL);
        check(rd_val == 32'h0001_0000, "R8 flag kept over read", rd_val, 32'h0001_0000);
        rd(A_CTL);
        check(rd_val == 32'h0, "R7 second read clear", rd_val, 32'h0);

        // R9: current-value write clears count and flag
        wr(A_RLD, 32'd2);
        wr(A_CUR, 32'h0);
        wr(A_CTL, 32'h5);
        repeat (6) @(negedge clk);
        wr(A_CTL, 32'h0);
        rd(A_CUR);
        check(rd_val == 32'd1, "R4 count after 8 steps", rd_val, 32'd1);
        wr(A_CUR, 32'h00AB_CDEF);
        rd(A_CUR);
        check(rd_val == 32'h0, "R9 count cleared", rd_val, 32'h0);
        rd(A_CTL);
        check(rd_val == 32'h0, "R9 flag cleared", rd_val, 32'h0);

        // R6: external reference steps
        wr(A_RLD, 32'd10);
        wr(A_CUR, 32'h0);
        ref_in = 1'b0;
        wr(A_CTL, 32'h1);
        repeat (6) @(negedge clk);
        rd(A_CUR);
        check(rd_val == 32'h0, "R6 no step while ref low", rd_val, 32'h0);
        for (int k = 0; k < 4; k++) begin
            ref_in = 1'b1;
            repeat (3) @(negedge clk);
            ref_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(A_CUR);
        check(rd_val == 32'd7, "R6 four reference edges", rd_val, 32'd7);
        ref_in = 1'b1;
        repeat (20) @(negedge clk);
        rd(A_CUR);
        check(rd_val == 32'd6, "R6 high level gives one step", rd_val, 32'd6);
        wr(A_CTL, 32'h0);

        finish_run();
    end

endmodule